// File: doc/BRIEF.md
# Three-Wire Dual Synthesizer Programming Port

This block is the serial configuration slave of a dual-channel frequency synthesizer. A host sends words over three wires: a serial clock, a serial data line and a load strobe. Every word carries its payload first and a two-bit group code last. When the load strobe rises, the block reads the last two bits it received as the group code and writes the payload into one of four destinations: the channel 1 divider setting, the channel 2 divider setting, the reference divider setting, or the control register.

Each group has its own word length and its own field layout. A word whose length does not match its group is dropped without effect. A reference setting below the minimum is also dropped. The serial wires are sampled in the system clock domain, and the host is expected to hold each serial level for at least one system clock. The outputs are the held settings, ready for the divider, charge-pump and standby logic that sit next to this block.

Top module: `synth_prog_if`

## Requirements
- R1: After reset, both channels hold swallow count 0 and main count 0, the reference divide value is 8, and every control output is 0.
- R2: One data bit is taken on each rising edge of `ser_clk`. A level held high takes no further bits. The word is decoded on the rising edge of `ser_load`, and the outputs change one system clock after that edge is seen. The bit count restarts at zero after every load.
- R3: A 19-bit word ending in group bits sent as 1 then 0 sets channel 1. The first 5 bits sent are the swallow count, least significant bit first. The next 12 bits are the main count, least significant bit first.
- R4: A 19-bit word ending in group bits sent as 0 then 1 sets channel 2, with the same layout as R3.
- R5: A 14-bit word ending in group bits sent as 1 then 1 sets the 12-bit reference divide value, least significant bit first.
- R6: A 14-bit word ending in group bits sent as 0 then 0 sets the control register. Its 12 payload bits are sent in this order: test, pump polarity, channel 1 current select (2 bits, LSB first), channel 1 standby, channel 2 current select (2 bits, LSB first), channel 2 standby, reference standby, lock-detect select 1, lock-detect select 2, filter switch.
- R7: A load updates only the destination named by its group code. All other outputs keep their values.
- R8: A word whose bit count differs from the length its group code requires changes no output. This includes a load with no bits at all.
- R9: A reference word whose value is below 8 changes no output. A value of exactly 8 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock; a bit is taken on its rising edge |
| ser_data | input | 1 | Serial data |
| ser_load | input | 1 | Load strobe; its rising edge decodes the word |
| ch1_swallow | output | 5 | Channel 1 swallow count |
| ch1_main | output | 12 | Channel 1 main count |
| ch2_swallow | output | 5 | Channel 2 swallow count |
| ch2_main | output | 12 | Channel 2 main count |
| ref_div | output | 12 | Reference divide value |
| ctl_test | output | 1 | Test mode bit |
| ctl_pol | output | 1 | Charge pump polarity reversal |
| ctl_cur1 | output | 2 | Channel 1 pump current select |
| ctl_cur2 | output | 2 | Channel 2 pump current select |
| ctl_sb1 | output | 1 | Channel 1 standby |
| ctl_sb2 | output | 1 | Channel 2 standby |
| ctl_sbr | output | 1 | Reference divider standby |
| ctl_ld1 | output | 1 | Lock-detect select bit 1 |
| ctl_ld2 | output | 1 | Lock-detect select bit 2 |
| ctl_sw | output | 1 | Filter switch |

## Verification
The assertions check several rules on every cycle. At most one destination is written per load. No write happens without a load edge. Each write matches the bit count its group needs. Destinations that were not written stay stable. The reference value never falls below 8. The bit counter advances by exactly one per serial edge. Only the bench's scenarios can show that the bit order and field placement are right and that the values are decoded correctly, because that needs a host-side model of the word format compared against the outputs.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

  typedef enum logic [1:0] {
    GRP_CTL = 2'b00,
    GRP_CH2 = 2'b01,
    GRP_CH1 = 2'b10,
    GRP_REF = 2'b11
  } grp_e;

  // Pull n bits out of v, where the bit sent first sits at v[msb].
  // The result holds the first-sent bit at position 0 (the LSB).
  function automatic logic [31:0] take_lsb_first(logic [63:0] v, int msb, int n);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < n && (msb - i) >= 0) r[i] = v[msb - i];
    end
    return r;
  endfunction

endpackage

// File: rtl/synth_prog_shifter.sv
module synth_prog_shifter #(
  parameter int SR_W  = 19,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_load,
  output logic [SR_W-1:0]  sr,
  output logic [CNT_W-1:0] cnt,
  output logic             bit_rise,
  output logic             load_rise
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(SR_W + 1);

  logic sclk_q, load_q;

  assign bit_rise  = ser_clk & ~sclk_q;
  assign load_rise = ser_load & ~load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      load_q <= 1'b0;
      sr     <= '0;
      cnt    <= '0;
    end else begin
      sclk_q <= ser_clk;
      load_q <= ser_load;
      if (load_rise) begin
        cnt <= '0;
      end else if (bit_rise) begin
        sr <= {sr[SR_W-2:0], ser_data};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/synth_prog_decoder.sv
module synth_prog_decoder
  import synth_prog_pkg::*;
#(
  parameter int SR_W    = 19,
  parameter int CNT_W   = 5,
  parameter int A_W     = 5,
  parameter int N_W     = 12,
  parameter int D_W     = 12,
  parameter int CTL_PAY = 12,
  parameter int REF_MIN = 8
) (
  input  logic [SR_W-1:0]    sr,
  input  logic [CNT_W-1:0]   cnt,
  input  logic               load_rise,
  output logic               wr_ch1,
  output logic               wr_ch2,
  output logic               wr_ref,
  output logic               wr_ctl,
  output logic [A_W-1:0]     a_val,
  output logic [N_W-1:0]     n_val,
  output logic [D_W-1:0]     d_val,
  output logic [CTL_PAY-1:0] ctl_val
);
  localparam int CH_LEN  = A_W + N_W + 2;
  localparam int REF_LEN = D_W + 2;
  localparam int CTL_LEN = CTL_PAY + 2;

  grp_e        grp;
  logic [63:0] srx;
  logic        len_ch, len_ref, len_ctl, ref_ok;

  assign srx = 64'(sr);
  assign grp = grp_e'({sr[1], sr[0]});

  assign a_val   = A_W'(take_lsb_first(srx, CH_LEN - 1, A_W));
  assign n_val   = N_W'(take_lsb_first(srx, CH_LEN - 1 - A_W, N_W));
  assign d_val   = D_W'(take_lsb_first(srx, REF_LEN - 1, D_W));
  assign ctl_val = CTL_PAY'(take_lsb_first(srx, CTL_LEN - 1, CTL_PAY));

  assign len_ch  = (cnt == CNT_W'(CH_LEN));
  assign len_ref = (cnt == CNT_W'(REF_LEN));
  assign len_ctl = (cnt == CNT_W'(CTL_LEN));
  assign ref_ok  = (32'(d_val) >= REF_MIN);

  assign wr_ch1 = load_rise && grp == GRP_CH1 && len_ch;
  assign wr_ch2 = load_rise && grp == GRP_CH2 && len_ch;
  assign wr_ref = load_rise && grp == GRP_REF && len_ref && ref_ok;
  assign wr_ctl = load_rise && grp == GRP_CTL && len_ctl;
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if #(
  parameter int A_W     = 5,
  parameter int N_W     = 12,
  parameter int D_W     = 12,
  parameter int CUR_W   = 2,
  parameter int REF_MIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_load,
  output logic [A_W-1:0]   ch1_swallow,
  output logic [N_W-1:0]   ch1_main,
  output logic [A_W-1:0]   ch2_swallow,
  output logic [N_W-1:0]   ch2_main,
  output logic [D_W-1:0]   ref_div,
  output logic             ctl_test,
  output logic             ctl_pol,
  output logic [CUR_W-1:0] ctl_cur1,
  output logic [CUR_W-1:0] ctl_cur2,
  output logic             ctl_sb1,
  output logic             ctl_sb2,
  output logic             ctl_sbr,
  output logic             ctl_ld1,
  output logic             ctl_ld2,
  output logic             ctl_sw
);
  localparam int CTL_PAY = 8 + 2 * CUR_W;
  localparam int CH_LEN  = A_W + N_W + 2;
  localparam int SR_W    = CH_LEN;
  localparam int CNT_W   = $clog2(SR_W + 2);
  // Field offsets inside the control payload, in sending order
  localparam int O_TEST = 0;
  localparam int O_POL  = 1;
  localparam int O_CUR1 = 2;
  localparam int O_SB1  = O_CUR1 + CUR_W;
  localparam int O_CUR2 = O_SB1 + 1;
  localparam int O_SB2  = O_CUR2 + CUR_W;
  localparam int O_SBR  = O_SB2 + 1;
  localparam int O_LD1  = O_SBR + 1;
  localparam int O_LD2  = O_LD1 + 1;
  localparam int O_SW   = O_LD2 + 1;

  logic [SR_W-1:0]    sr;
  logic [CNT_W-1:0]   cnt;
  logic               bit_rise, load_rise;
  logic               wr_ch1, wr_ch2, wr_ref, wr_ctl;
  logic [A_W-1:0]     a_val;
  logic [N_W-1:0]     n_val;
  logic [D_W-1:0]     d_val;
  logic [CTL_PAY-1:0] ctl_val, ctl_q;

  synth_prog_shifter #(.SR_W(SR_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .sr(sr), .cnt(cnt), .bit_rise(bit_rise),
    .load_rise(load_rise)
  );

  synth_prog_decoder #(
    .SR_W(SR_W), .CNT_W(CNT_W), .A_W(A_W), .N_W(N_W), .D_W(D_W),
    .CTL_PAY(CTL_PAY), .REF_MIN(REF_MIN)
  ) u_dec (
    .sr(sr), .cnt(cnt), .load_rise(load_rise),
    .wr_ch1(wr_ch1), .wr_ch2(wr_ch2), .wr_ref(wr_ref), .wr_ctl(wr_ctl),
    .a_val(a_val), .n_val(n_val), .d_val(d_val), .ctl_val(ctl_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch1_swallow <= '0;
      ch1_main    <= '0;
      ch2_swallow <= '0;
      ch2_main    <= '0;
      ref_div     <= D_W'(REF_MIN);
      ctl_q       <= '0;
    end else begin
      if (wr_ch1) begin
        ch1_swallow <= a_val;
        ch1_main    <= n_val;
      end
      if (wr_ch2) begin
        ch2_swallow <= a_val;
        ch2_main    <= n_val;
      end
      if (wr_ref) ref_div <= d_val;
      if (wr_ctl) ctl_q <= ctl_val;
    end
  end

  assign ctl_test = ctl_q[O_TEST];
  assign ctl_pol  = ctl_q[O_POL];
  assign ctl_cur1 = ctl_q[O_CUR1 +: CUR_W];
  assign ctl_sb1  = ctl_q[O_SB1];
  assign ctl_cur2 = ctl_q[O_CUR2 +: CUR_W];
  assign ctl_sb2  = ctl_q[O_SB2];
  assign ctl_sbr  = ctl_q[O_SBR];
  assign ctl_ld1  = ctl_q[O_LD1];
  assign ctl_ld2  = ctl_q[O_LD2];
  assign ctl_sw   = ctl_q[O_SW];
endmodule

// File: rtl/synth_prog_if_chk.sv
module synth_prog_if_chk #(
  parameter int A_W     = 5,
  parameter int N_W     = 12,
  parameter int D_W     = 12,
  parameter int CTL_PAY = 12,
  parameter int CNT_W   = 5,
  parameter int REF_MIN = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bit_rise,
  input logic               load_rise,
  input logic [CNT_W-1:0]   cnt,
  input logic               wr_ch1,
  input logic               wr_ch2,
  input logic               wr_ref,
  input logic               wr_ctl,
  input logic [A_W-1:0]     ch1_swallow,
  input logic [N_W-1:0]     ch1_main,
  input logic [A_W-1:0]     ch2_swallow,
  input logic [N_W-1:0]     ch2_main,
  input logic [D_W-1:0]     ref_div,
  input logic [CTL_PAY-1:0] ctl_q
);
  localparam int CH_LEN  = A_W + N_W + 2;
  localparam int REF_LEN = D_W + 2;
  localparam int CTL_LEN = CTL_PAY + 2;

  a_r7_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ch1, wr_ch2, wr_ref, wr_ctl}));

  a_r2_write_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load_rise |-> !(wr_ch1 || wr_ch2 || wr_ref || wr_ctl));

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_rise && !load_rise && cnt < CNT_W'(CH_LEN)) |=> cnt == $past(cnt) + 1'b1);

  a_r2_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    load_rise |=> cnt == '0);

  a_r8_ch_length: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ch1 || wr_ch2) |-> cnt == CNT_W'(CH_LEN));

  a_r8_short_length: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ref |-> cnt == CNT_W'(REF_LEN));

  a_r8_ctl_length: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |-> cnt == CNT_W'(CTL_LEN));

  a_r9_ref_floor: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ref_div) >= REF_MIN);

  a_r7_ch1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ch1 |=> $stable(ch1_swallow) && $stable(ch1_main));

  a_r7_ch2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ch2 |=> $stable(ch2_swallow) && $stable(ch2_main));

  a_r7_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ref |=> $stable(ref_div));

  a_r7_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> $stable(ctl_q));
endmodule

bind synth_prog_if synth_prog_if_chk #(
  .A_W(A_W), .N_W(N_W), .D_W(D_W), .CTL_PAY(CTL_PAY), .CNT_W(CNT_W),
  .REF_MIN(REF_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .load_rise(load_rise),
  .cnt(cnt), .wr_ch1(wr_ch1), .wr_ch2(wr_ch2), .wr_ref(wr_ref),
  .wr_ctl(wr_ctl), .ch1_swallow(ch1_swallow), .ch1_main(ch1_main),
  .ch2_swallow(ch2_swallow), .ch2_main(ch2_main), .ref_div(ref_div),
  .ctl_q(ctl_q)
);

// File: tb/synth_prog_if_bench.sv
module synth_prog_if_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic [4:0]  ch1_swallow, ch2_swallow;
  logic [11:0] ch1_main, ch2_main, ref_div;
  logic ctl_test, ctl_pol, ctl_sb1, ctl_sb2, ctl_sbr, ctl_ld1, ctl_ld2, ctl_sw;
  logic [1:0] ctl_cur1, ctl_cur2;

  int  n_run = 0, n_fail = 0;
  bit  finished = 0;

  // Model of the expected outputs
  logic [4:0]  e_a1, e_a2;
  logic [11:0] e_n1, e_n2, e_ref, e_ctl;

  always #(CLK_PERIOD / 2) clk = ~clk;

  synth_prog_if u_synth_prog_if (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .ch1_swallow(ch1_swallow), .ch1_main(ch1_main),
    .ch2_swallow(ch2_swallow), .ch2_main(ch2_main), .ref_div(ref_div),
    .ctl_test(ctl_test), .ctl_pol(ctl_pol), .ctl_cur1(ctl_cur1),
    .ctl_cur2(ctl_cur2), .ctl_sb1(ctl_sb1), .ctl_sb2(ctl_sb2),
    .ctl_sbr(ctl_sbr), .ctl_ld1(ctl_ld1), .ctl_ld2(ctl_ld2), .ctl_sw(ctl_sw)
  );

  // Control payload in sending order, bit 0 sent first (R6)
  function automatic logic [11:0] ctl_pack(logic t, logic p, logic [1:0] c1,
      logic s1, logic [1:0] c2, logic s2, logic sr, logic l1, logic l2, logic w);
    return {w, l2, l1, sr, s2, c2, s1, c1, p, t};
  endfunction

  function automatic logic [63:0] observed();
    return {6'd0, ch1_swallow, ch1_main, ch2_swallow, ch2_main, ref_div,
            ctl_pack(ctl_test, ctl_pol, ctl_cur1, ctl_sb1, ctl_cur2, ctl_sb2,
                     ctl_sbr, ctl_ld1, ctl_ld2, ctl_sw)};
  endfunction

  function automatic logic [63:0] expected();
    return {6'd0, e_a1, e_n1, e_a2, e_n2, e_ref, e_ctl};
  endfunction

  // Word image, bit i is sent i-th; group bits sent last, g[1] first
  function automatic logic [31:0] ch_word(logic [4:0] a, logic [11:0] n, logic [1:0] g);
    return {13'd0, g[0], g[1], n, a};
  endfunction

  function automatic logic [31:0] short_word(logic [11:0] p, logic [1:0] g);
    return {18'd0, g[0], g[1], p};
  endfunction

  task automatic check(string tag);
    logic [63:0] got, exp;
    got = observed();
    exp = expected();
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // R2: bit taken on the rising serial edge; level held for several clocks
  task automatic send_bit(logic b);
    @(negedge clk) ser_data = b;
    @(negedge clk) ser_clk = 1'b1;
    repeat (3) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  // extra: 0 exact, 1 one junk bit first, -1 first bit dropped
  task automatic send_word(logic [31:0] w, int len, int extra);
    if (extra == 1) send_bit(1'($urandom));
    for (int i = (extra == -1) ? 1 : 0; i < len; i++) send_bit(w[i]);
    @(negedge clk) ser_load = 1'b1;
    repeat (2) @(negedge clk);
    ser_load = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_ch(int ch, logic [4:0] a, logic [11:0] n, int extra, string tag);
    send_word(ch_word(a, n, ch == 1 ? 2'b10 : 2'b01), 19, extra);
    if (extra == 0) begin
      if (ch == 1) begin e_a1 = a; e_n1 = n; end
      else begin e_a2 = a; e_n2 = n; end
    end
    check(tag);
  endtask

  task automatic do_ref(logic [11:0] d, int extra, string tag);
    send_word(short_word(d, 2'b11), 14, extra);
    if (extra == 0 && d >= 12'd8) e_ref = d;
    check(tag);
  endtask

  task automatic do_ctl(logic [11:0] c, int extra, string tag);
    send_word(short_word(c, 2'b00), 14, extra);
    if (extra == 0) e_ctl = c;
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    e_a1 = '0; e_n1 = '0; e_a2 = '0; e_n2 = '0; e_ref = 12'd8; e_ctl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state");

    do_ch(1, 5'd31, 12'd4095, 0, "R3 ch1 all ones");
    do_ch(2, 5'd0, 12'd1, 0, "R4 ch2 min / R7 ch1 held");
    do_ch(1, 5'b00001, 12'b1000_0000_0001, 0, "R3 ch1 bit order");
    do_ref(12'd8, 0, "R9 ref at floor accepted");
    do_ref(12'd7, 0, "R9 ref below floor rejected");
    do_ref(12'd4095, 0, "R5 ref max");
    do_ctl(ctl_pack(1'b1, 1'b0, 2'b01, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1),
           0, "R6 control fields");
    do_ch(1, 5'd5, 12'd77, -1, "R8 ch1 short word");
    do_ctl(12'hFFF, 1, "R8 control long word");
    do_ref(12'd100, -1, "R8 ref short word");
    // R8: load with no bits at all
    @(negedge clk) ser_load = 1'b1;
    repeat (2) @(negedge clk);
    ser_load = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 empty load");
    do_ch(2, 5'd17, 12'd2049, 0, "R2 ch2 after empty load");

    for (int k = 0; k < 60; k++) begin
      int kind, ex;
      kind = int'($urandom_range(0, 3));
      ex = ($urandom_range(0, 5) == 0) ? (($urandom_range(0, 1) == 0) ? 1 : -1) : 0;
      case (kind)
        0: do_ch(1, 5'($urandom), 12'($urandom), ex, "R3/R7/R8 random ch1");
        1: do_ch(2, 5'($urandom), 12'($urandom), ex, "R4/R7/R8 random ch2");
        2: do_ref(($urandom_range(0, 3) == 0) ? 12'($urandom_range(0, 9)) : 12'($urandom),
                  ex, "R5/R9/R8 random ref");
        default: do_ctl(12'($urandom), ex, "R6/R7/R8 random control");
      endcase
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule